// File: doc/BRIEF.md
# Clos Middle-Stage Route Colorer

This block takes a connection request for a three-stage Clos fabric and chooses a middle-stage switch for every connection. The fabric has M first-stage switches of PPS ports each, M third-stage switches of PPS ports each, and exactly PPS middle switches. A connection joins an input port to an output port. Two connections may not use the same middle switch if they enter through the same first-stage switch. The same rule applies if they leave through the same third-stage switch. Finding such an assignment is an edge colouring of a bipartite multigraph. In that graph the first-stage and third-stage switches are the vertices, each connection is an edge, and each middle switch is a colour.

The engine first fills a partial request with stand-in connections so that every switch carries exactly PPS edges. It then splits the graph in half, log2(PPS) times. In each split it walks closed trails of edges that are not yet split. Consecutive edges of a trail go into opposite halves, so every vertex loses exactly half of its edges to each side. Every split decides one more bit of each edge's colour, starting with the most significant bit. After the last split, each group of edges is one colour.

A scheduler hands over the request and pulses `start`. It then waits for `done` and drives the crossbars from `mid`.

Top module: `clos_colorer`

## Requirements
- R1: After reset, `busy` and `done` are low and every `mid` entry is 0.
- R2: A `start` pulse while `busy` is low is accepted. At that clock edge the block samples `req_vld` and `req_dst`. In the next cycle `busy` is high and `done` is low.
- R3: A `start` pulse while `busy` is high is ignored. The request under way finishes and reports the colouring of the request that was accepted first.
- R4: `done` rises at most CW*(3N/2+1) cycles after the accepting edge (50 with defaults). `busy` falls in the same cycle. `busy` and `done` are never high together.
- R5: When `done` is high, no two valid input ports report the same `mid` if they belong to the same first-stage switch. The first-stage switch of port p is p / PPS.
- R6: When `done` is high, no two valid input ports report the same `mid` if their destinations belong to the same third-stage switch. `req_dst[p]` is the output port number, and its third-stage switch is `req_dst[p]` / PPS.
- R7: For a full permutation (all ports valid), each first-stage switch and each third-stage switch uses each of the PPS middle indices exactly once.
- R8: When `done` is high, every port whose `req_vld` bit was low reports `mid` 0. This holds for any subset of valid ports, including none, provided the valid destinations are distinct.
- R9: Once `done` is high, `done` and all `mid` values stay unchanged until a new `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin routing the presented request |
| req_vld | input | N | Port p requests a connection |
| req_dst | input | N x PW | Output port number for each input port |
| busy | output | 1 | Routing in progress |
| done | output | 1 | Colouring complete; held until the next accepted start |
| mid | output | N x CW | Middle-stage switch index for each input port |

## Verification
A wrong split bit or a stray trail step shows up as two ports of one switch sharing a middle index. The first-stage or third-stage conflict check sees this in the first cycle that `done` is high. A broken padding stage leaves a vertex with odd degree. The trail then stalls off its starting vertex, so the result has a conflict, a late `done`, or a non-zero index on an unused port. A restart or a loss of state during the hold period changes `mid` or drops `done` in the very next cycle, and the per-cycle comparison catches it there.

// File: rtl/clos_pkg.sv
package clos_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEEK = 2'd1,
        PH_WALK = 2'd2
    } phase_e;

endpackage

// File: rtl/clos_pad.sv
// Completes a partial permutation: the k-th unused input (ascending index)
// is tied to the k-th unused output, so every switch reaches full degree.
module clos_pad #(
    parameter int N  = 16,
    parameter int PW = 4
) (
    input  logic [N-1:0]         vld,
    input  logic [N-1:0][PW-1:0] dst,
    output logic [N-1:0][PW-1:0] fill_dst
);

    logic [N-1:0]        used;
    logic [N-1:0][PW:0]  in_rank;
    logic [N-1:0][PW:0]  out_rank;
    logic [PW:0]         run_in;
    logic [PW:0]         run_out;

    always_comb begin
        used = '0;
        for (int i = 0; i < N; i++) begin
            if (vld[i]) used[dst[i]] = 1'b1;
        end

        run_in  = '0;
        run_out = '0;
        for (int i = 0; i < N; i++) begin
            in_rank[i]  = run_in;
            out_rank[i] = run_out;
            if (!vld[i])  run_in  = run_in + 1'b1;
            if (!used[i]) run_out = run_out + 1'b1;
        end

        for (int i = 0; i < N; i++) begin
            fill_dst[i] = dst[i];
            if (!vld[i]) begin
                for (int o = 0; o < N; o++) begin
                    if (!used[o] && (out_rank[o] == in_rank[i])) fill_dst[i] = PW'(o);
                end
            end
        end
    end

endmodule

// File: rtl/clos_pick.sv
// Lowest-index one-hot pick over a request mask.
module clos_pick #(
    parameter int W  = 16,
    parameter int IW = 4
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/clos_cand.sv
// Marks edges that may continue the current trail: not yet split in this
// round, in the same colour class, and touching the current vertex.
module clos_cand #(
    parameter int N   = 16,
    parameter int CW  = 2,
    parameter int SWW = 2,
    parameter int LSH = 2
) (
    input  logic [N-1:0]          seen,
    input  logic [N-1:0][CW-1:0]  color,
    input  logic [N-1:0][SWW-1:0] rsw,
    input  logic [CW-1:0]         cls,
    input  logic [CW-1:0]         pmask,
    input  logic [SWW-1:0]        cur,
    input  logic                  on_right,
    output logic [N-1:0]          cand
);

    for (genvar e = 0; e < N; e++) begin : g_edge
        localparam logic [SWW-1:0] LSW = SWW'(e >> LSH);
        logic same_cls;
        logic touch;
        assign same_cls = (((color[e] ^ cls) & pmask) == '0);
        assign touch    = on_right ? (rsw[e] == cur) : (LSW == cur);
        assign cand[e]  = !seen[e] && same_cls && touch;
    end

endmodule

// File: rtl/clos_colorer.sv
module clos_colorer #(
    parameter int M   = 4,
    parameter int PPS = 4,
    localparam int N   = M * PPS,
    localparam int PW  = $clog2(N),
    localparam int CW  = $clog2(PPS),
    localparam int LSH = CW,
    localparam int SWW = PW - LSH,
    localparam int RW  = (CW > 1) ? $clog2(CW) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [N-1:0]         req_vld,
    input  logic [N-1:0][PW-1:0] req_dst,
    output logic                 busy,
    output logic                 done,
    output logic [N-1:0][CW-1:0] mid
);
    import clos_pkg::*;

    typedef struct packed {
        phase_e                 phase;
        logic [RW-1:0]          round;
        logic [N-1:0]           seen;
        logic [N-1:0][CW-1:0]   color;
        logic [N-1:0][SWW-1:0]  rsw;
        logic [N-1:0]           vld;
        logic [SWW-1:0]         cur;
        logic                   on_right;
        logic                   nbit;
        logic [CW-1:0]          cls;
        logic                   done;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0][PW-1:0] fill_dst;
    logic [CW-1:0]        pmask;
    logic [N-1:0]         walk_req;
    logic                 seek_found, walk_found;
    logic [PW-1:0]        seek_idx, walk_idx;
    int                   bitpos;

    clos_pad #(.N(N), .PW(PW)) u_pad (
        .vld      (req_vld),
        .dst      (req_dst),
        .fill_dst (fill_dst)
    );

    always_comb begin
        bitpos = CW - 1 - int'(st_q.round);
        for (int b = 0; b < CW; b++) pmask[b] = (b > bitpos);
    end

    clos_cand #(.N(N), .CW(CW), .SWW(SWW), .LSH(LSH)) u_cand (
        .seen     (st_q.seen),
        .color    (st_q.color),
        .rsw      (st_q.rsw),
        .cls      (st_q.cls),
        .pmask    (pmask),
        .cur      (st_q.cur),
        .on_right (st_q.on_right),
        .cand     (walk_req)
    );

    clos_pick #(.W(N), .IW(PW)) u_pick_seek (
        .req   (~st_q.seen),
        .found (seek_found),
        .idx   (seek_idx)
    );

    clos_pick #(.W(N), .IW(PW)) u_pick_walk (
        .req   (walk_req),
        .found (walk_found),
        .idx   (walk_idx)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_SEEK;
                    st_d.round = '0;
                    st_d.seen  = '0;
                    st_d.color = '0;
                    st_d.vld   = req_vld;
                    st_d.done  = 1'b0;
                    for (int e = 0; e < N; e++) st_d.rsw[e] = fill_dst[e][PW-1:LSH];
                end
            end
            PH_SEEK: begin
                if (seek_found) begin
                    // open a new trail: first edge goes to the lower half
                    st_d.seen[seek_idx]          = 1'b1;
                    st_d.color[seek_idx][bitpos] = 1'b0;
                    st_d.cls      = st_q.color[seek_idx];
                    st_d.cur      = st_q.rsw[seek_idx];
                    st_d.on_right = 1'b1;
                    st_d.nbit     = 1'b1;
                    st_d.phase    = PH_WALK;
                end else if (st_q.round == RW'(CW - 1)) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.round = st_q.round + RW'(1);
                    st_d.seen  = '0;
                end
            end
            PH_WALK: begin
                if (walk_found) begin
                    st_d.seen[walk_idx]          = 1'b1;
                    st_d.color[walk_idx][bitpos] = st_q.nbit;
                    st_d.cur      = st_q.on_right ? walk_idx[PW-1:LSH] : st_q.rsw[walk_idx];
                    st_d.on_right = !st_q.on_right;
                    st_d.nbit     = !st_q.nbit;
                end else begin
                    st_d.phase = PH_SEEK;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = (st_q.phase != PH_IDLE);
    assign done = st_q.done;

    for (genvar p = 0; p < N; p++) begin : g_mid
        assign mid[p] = st_q.vld[p] ? st_q.color[p] : '0;
    end

endmodule

// File: rtl/clos_colorer_chk.sv
module clos_colorer_chk #(
    parameter int M   = 4,
    parameter int PPS = 4,
    localparam int N     = M * PPS,
    localparam int PW    = $clog2(N),
    localparam int CW    = $clog2(PPS),
    localparam int LSH   = CW,
    localparam int BOUND = CW * (3 * N / 2 + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [N-1:0]         req_vld,
    input logic [N-1:0][PW-1:0] req_dst,
    input logic                 busy,
    input logic                 done,
    input logic [N-1:0][CW-1:0] mid
);

    logic [N-1:0]         lv;
    logic [N-1:0][PW-1:0] ld;
    logic [15:0]          cnt;
    logic                 conf_l, conf_r, idle_bad;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lv  <= '0;
            ld  <= '0;
            cnt <= '0;
        end else if (start && !busy) begin
            lv  <= req_vld;
            ld  <= req_dst;
            cnt <= '0;
        end else if (busy && cnt != 16'hffff) begin
            cnt <= cnt + 16'd1;
        end
    end

    always_comb begin
        conf_l   = 1'b0;
        conf_r   = 1'b0;
        idle_bad = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!lv[i] && mid[i] != '0) idle_bad = 1'b1;
            for (int j = i + 1; j < N; j++) begin
                if (lv[i] && lv[j] && mid[i] == mid[j]) begin
                    if ((i / PPS) == (j / PPS)) conf_l = 1'b1;
                    if (ld[i][PW-1:LSH] == ld[j][PW-1:LSH]) conf_r = 1'b1;
                end
            end
        end
    end

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    // R4
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R4
    finish_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R4
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= 16'(BOUND)));

    // R5
    first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !conf_l);

    // R6
    third_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !conf_r);

    // R8
    idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !idle_bad);

    // R9
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(mid)));

endmodule

bind clos_colorer clos_colorer_chk #(.M(M), .PPS(PPS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .req_vld (req_vld),
    .req_dst (req_dst),
    .busy    (busy),
    .done    (done),
    .mid     (mid)
);

// File: tb/clos_colorer_tb.sv
`timescale 1ns/1ps
module clos_colorer_tb;
    localparam int M   = 4;
    localparam int PPS = 4;
    localparam int N   = M * PPS;
    localparam int PW  = 4;
    localparam int CW  = 2;
    localparam int LAT = CW * (3 * N / 2 + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [N-1:0]         req_vld = '0;
    logic [N-1:0][PW-1:0] req_dst = '0;
    logic                 busy, done;
    logic [N-1:0][CW-1:0] mid;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    clos_colorer #(.M(M), .PPS(PPS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_vld(req_vld),
        .req_dst(req_dst), .busy(busy), .done(done), .mid(mid)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // per-cycle model: result held while no start is accepted
    logic                 pd = 1'b0, pacc = 1'b0, armed = 1'b0;
    logic [N-1:0][CW-1:0] pm = '0;
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (armed) begin
                chk(!(busy && done), "R4 busy/done overlap", {busy, done}, 0);
                if (pd && !pacc) begin
                    chk(done == 1'b1, "R9 done held", done, 1);
                    chk(mid == pm, "R9 mid held", mid, pm);
                end
            end
            pd    = done;
            pm    = mid;
            pacc  = start && !busy;
            armed = 1'b1;
        end
    end

    task automatic verify(input logic [N-1:0] v, input logic [N-1:0][PW-1:0] d);
        int cl = 0, cr = 0, idle = 0, dup = 0;
        for (int i = 0; i < N; i++) begin
            if (!v[i] && mid[i] != '0) idle++;
            for (int j = i + 1; j < N; j++) begin
                if (v[i] && v[j] && mid[i] == mid[j]) begin
                    if (i / PPS == j / PPS) cl++;
                    if (d[i] / PPS == d[j] / PPS) cr++;
                end
            end
        end
        chk(cl == 0, "R5 first-stage conflicts", cl, 0);
        chk(cr == 0, "R6 third-stage conflicts", cr, 0);
        chk(idle == 0, "R8 unused ports non-zero", idle, 0);
        if (v == '1) begin
            for (int s = 0; s < M; s++) begin
                for (int c = 0; c < PPS; c++) begin
                    int nl = 0, nr = 0;
                    for (int p = 0; p < N; p++) begin
                        if (p / PPS == s && mid[p] == c) nl++;
                        if (d[p] / PPS == s && mid[p] == c) nr++;
                    end
                    if (nl != 1 || nr != 1) dup++;
                end
            end
            chk(dup == 0, "R7 colour use per switch", dup, 0);
        end
    endtask

    task automatic wait_done(input int lat0);
        int lat = lat0;
        while (!done && lat < LAT + 10) begin
            @(negedge clk);
            lat++;
        end
        chk(done && lat <= LAT, "R4 done latency", lat, LAT);
        chk(!busy, "R4 busy low at done", busy, 0);
    endtask

    task automatic run(input logic [N-1:0] v, input logic [N-1:0][PW-1:0] d);
        @(negedge clk);
        req_vld = v;
        req_dst = d;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        chk(busy && !done, "R2 accepted start", {busy, done}, 2);
        wait_done(1);
        verify(v, d);
    endtask

    task automatic rand_perm(output logic [N-1:0][PW-1:0] d);
        int a[N];
        for (int i = 0; i < N; i++) a[i] = i;
        for (int i = N - 1; i > 0; i--) begin
            int j = $urandom_range(i, 0);
            int t = a[i];
            a[i] = a[j];
            a[j] = t;
        end
        for (int i = 0; i < N; i++) d[i] = PW'(a[i]);
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [N-1:0][PW-1:0] d;
        logic [N-1:0]         v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R1 flags after reset", {busy, done}, 0);
        chk(mid == '0, "R1 mid after reset", mid, 0);

        // identity
        for (int i = 0; i < N; i++) d[i] = PW'(i);
        run('1, d);
        // reversal
        for (int i = 0; i < N; i++) d[i] = PW'(N - 1 - i);
        run('1, d);
        // each first-stage switch to one third-stage switch: parallel edges
        for (int i = 0; i < N; i++) d[i] = PW'(((i / PPS + 1) % M) * PPS + (i % PPS));
        run('1, d);
        // spread: port p goes to switch p mod M
        for (int i = 0; i < N; i++) d[i] = PW'((i % M) * PPS + i / M);
        run('1, d);
        // random full permutations
        for (int k = 0; k < 6; k++) begin
            rand_perm(d);
            run('1, d);
        end
        // partial requests
        for (int k = 0; k < 4; k++) begin
            rand_perm(d);
            for (int i = 0; i < N; i++) v[i] = ($urandom_range(1, 0) == 1);
            run(v, d);
        end
        // empty request
        run('0, d);
        // R9 hold for a while with no start
        repeat (12) @(negedge clk);

        // R3: second start during routing must not restart or replace
        for (int i = 0; i < N; i++) d[i] = PW'((i * 5) % N);
        @(negedge clk);
        req_vld = '1;
        req_dst = d;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        chk(busy, "R2 accepted start", busy, 1);
        repeat (4) @(negedge clk);
        req_vld = '0;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        chk(busy && !done, "R3 still routing after busy start", {busy, done}, 2);
        wait_done(6);
        verify('1, d);

        // restart after done
        rand_perm(d);
        run('1, d);

        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule